// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight asynchronous interrupt pins and turns each into a latched request for a processor. Every pin is brought into the clock domain through two flops, then tested against its own detection rule: rising edge, falling edge, either edge, high level or low level. A detected event latches a pending flag. A pin's request output is raised while its flag is pending, its mask is open and its 4-bit priority field is nonzero. A single combined output is the OR of all pin requests.

Software reaches the state through a plain 32-bit register port with a 3-bit register index. Reads are combinational and writes take effect at the clock edge. In the status, mask-set and mask-clear registers, pin 0 is the most significant bit. Pending flags are cleared by writing zero to their bit. Masking uses one register that sets mask bits and another that clears them. The usual bring-up is: leave the priority fields at zero, clear the pending register, then write 0xF into each pin's priority field. The register port has no back-pressure: every access completes in the cycle it is presented. There is no streamed data in this block, so no valid/ready interface is used.

Top module: `irqpin_ctrl`

## Requirements
- R1: After reset, the sense, priority and pending registers read 0, the mask register (index 3) reads 0xFF000000 with all eight pins masked, and every request output is low.
- R2: In the pending (index 2), mask-set (index 3) and mask-clear (index 4) registers, pin n is bit 31-n.
- R3: The sense register (index 0) holds one field of SENSE_W bits per pin (default 4), with the field for pin n starting at bit 32-(n+1)*SENSE_W. Codes: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 both edges.
- R4: In rising-edge mode, a low-to-high pin transition sets the pending flag, and a high-to-low transition does not.
- R5: In falling-edge mode, a high-to-low transition sets the pending flag, and a low-to-high transition does not.
- R6: In both-edges mode, either transition sets the pending flag.
- R7: In a level mode, the pending flag is set on every cycle the level is active. A clearing write has no lasting effect until the level has gone.
- R8: A write to the pending register clears each flag whose bit is written 0 and leaves flags written 1 unchanged. A detection in the same cycle takes precedence over the clear.
- R9: Writing 1 to a pin's bit in the mask-set register masks the pin, and writing 1 in the mask-clear register unmasks it. Zero bits in either register leave the mask unchanged.
- R10: The priority register (index 1) holds a 4-bit field per pin, with pin 0 in bits 31:28. A zero field blocks the pin's request output but does not prevent its pending flag from latching.
- R11: The request for pin n equals pending AND NOT masked AND priority field nonzero. The combined output is the OR of all pin requests.
- R12: A pin change presented before clock edge k shows in the pending register after edge k+2, and not after edge k+1.
- R13: Sense codes 5 to 15 detect nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous interrupt pins |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index (0 sense, 1 priority, 2 pending, 3 mask-set, 4 mask-clear) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| irq_o | output | NUM_PINS | Per-pin request outputs |
| irq_any_o | output | 1 | OR of all pin requests |

## Verification
Each detection mode is driven with both pin transitions. This separates rising, falling and both-edges behaviour, and shows that an idle pin in level mode keeps re-latching. A held level is combined with clearing writes, which tells "set wins" apart from "clear wins". Writes that set only some of the ones or zeros in the pending, mask and priority registers show that each bit position belongs to the intended pin and that unwritten bits are preserved. Invalid sense codes and a cycle-by-cycle latency probe complete the set.

// File: rtl/irqpin_pkg.sv
package irqpin_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned MAX_PINS = 8;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned CODE_W = 4;

  localparam logic [2:0] IDX_SENSE = 3'd0;
  localparam logic [2:0] IDX_PRIO  = 3'd1;
  localparam logic [2:0] IDX_PEND  = 3'd2;
  localparam logic [2:0] IDX_MSET  = 3'd3;
  localparam logic [2:0] IDX_MCLR  = 3'd4;

  localparam logic [CODE_W-1:0] MODE_FALL = 4'd0;
  localparam logic [CODE_W-1:0] MODE_RISE = 4'd1;
  localparam logic [CODE_W-1:0] MODE_LOW  = 4'd2;
  localparam logic [CODE_W-1:0] MODE_HIGH = 4'd3;
  localparam logic [CODE_W-1:0] MODE_BOTH = 4'd4;
endpackage

// File: rtl/irqpin_sync.sv
module irqpin_sync #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] now_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] meta_q, now_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      now_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      now_q  <= meta_q;
      prev_q <= now_q;
    end
  end

  assign now_o  = now_q;
  assign prev_o = prev_q;

  AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> prev_q == $past(now_q)); // R12
endmodule

// File: rtl/irqpin_detect.sv
module irqpin_detect
  import irqpin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_i,
  input  logic              lvl_d_i,
  input  logic [CODE_W-1:0] mode_i,
  output logic              hit_o
);
  logic rise, fall;

  assign rise = lvl_i & ~lvl_d_i;
  assign fall = ~lvl_i & lvl_d_i;

  always_comb begin
    unique case (mode_i)
      MODE_FALL: hit_o = fall;
      MODE_RISE: hit_o = rise;
      MODE_LOW:  hit_o = ~lvl_i;
      MODE_HIGH: hit_o = lvl_i;
      MODE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end

  AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && (mode_i == MODE_RISE || mode_i == MODE_FALL))
      |=> !(hit_o && $stable(mode_i))); // R4
endmodule

// File: rtl/irqpin_regs.sv
module irqpin_regs
  import irqpin_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned SW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_req,
  input  logic                   bus_we,
  input  logic [2:0]             bus_addr,
  input  logic [BUS_W-1:0]       bus_wdata,
  output logic [BUS_W-1:0]       bus_rdata,
  input  logic [N-1:0]           hit_i,
  output logic [N-1:0][CODE_W-1:0] mode_o,
  output logic [N-1:0]           pend_o,
  output logic [N-1:0]           mask_o,
  output logic [N-1:0]           prio_on_o
);
  logic [N-1:0][SW-1:0]     sense_q;
  logic [N-1:0][PRIO_W-1:0] prio_q;
  logic [N-1:0]             pend_q;
  logic [N-1:0]             mask_q;
  logic                     wr, rd;

  assign wr = bus_req & bus_we;
  assign rd = bus_req & ~bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      prio_q  <= '0;
      pend_q  <= '0;
      mask_q  <= '1;
    end else begin
      for (int n = 0; n < N; n++) begin
        if (wr && bus_addr == IDX_SENSE)
          sense_q[n] <= bus_wdata[BUS_W-(n+1)*SW +: SW];
        if (wr && bus_addr == IDX_PRIO)
          prio_q[n] <= bus_wdata[BUS_W-(n+1)*PRIO_W +: PRIO_W];
        if (hit_i[n])
          pend_q[n] <= 1'b1;
        else if (wr && bus_addr == IDX_PEND && !bus_wdata[BUS_W-1-n])
          pend_q[n] <= 1'b0;
        if (wr && bus_addr == IDX_MSET && bus_wdata[BUS_W-1-n])
          mask_q[n] <= 1'b1;
        else if (wr && bus_addr == IDX_MCLR && bus_wdata[BUS_W-1-n])
          mask_q[n] <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      for (int n = 0; n < N; n++) begin
        case (bus_addr)
          IDX_SENSE: bus_rdata[BUS_W-(n+1)*SW +: SW] = sense_q[n];
          IDX_PRIO:  bus_rdata[BUS_W-(n+1)*PRIO_W +: PRIO_W] = prio_q[n];
          IDX_PEND:  bus_rdata[BUS_W-1-n] = pend_q[n];
          IDX_MSET:  bus_rdata[BUS_W-1-n] = mask_q[n];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    for (int n = 0; n < N; n++) begin
      mode_o[n]    = CODE_W'(sense_q[n]);
      prio_on_o[n] = |prio_q[n];
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && bus_addr == IDX_PEND) && hit_i == '0) |=> $stable(pend_q)); // R8

  for (genvar g = 0; g < N; g++) begin : g_chk
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == IDX_PEND && !bus_wdata[BUS_W-1-g] && !hit_i[g])
        |=> !pend_q[g]); // R8
    AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i[g] |=> pend_q[g]); // R7
  end
endmodule

// File: rtl/irqpin_ctrl.sv
module irqpin_ctrl
  import irqpin_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned SENSE_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [2:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_PINS-1:0] irq_o,
  output logic                irq_any_o
);
  localparam int unsigned SENSE_BITS = NUM_PINS * SENSE_W;

  initial begin
    assert (NUM_PINS >= 1 && NUM_PINS <= MAX_PINS);
    assert (SENSE_W == 2 || SENSE_W == 4);
    assert (SENSE_BITS <= BUS_W);
  end

  logic [NUM_PINS-1:0]             lvl, lvl_d, hit, pend, mask, prio_on;
  logic [NUM_PINS-1:0][CODE_W-1:0] mode;

  irqpin_sync #(.N(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(pin_i), .now_o(lvl), .prev_o(lvl_d)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irqpin_detect u_det (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl[g]), .lvl_d_i(lvl_d[g]),
      .mode_i(mode[g]), .hit_o(hit[g])
    );
    assign irq_o[g] = pend[g] & ~mask[g] & prio_on[g];

    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == IDX_MSET && bus_wdata[31-g])
        |=> !irq_o[g]); // R9
    AST_PRIO_ZERO_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == IDX_PRIO && bus_wdata[28-4*g +: 4] == 4'h0)
        |=> !irq_o[g]); // R10
  end

  assign irq_any_o = |irq_o;

  irqpin_regs #(.N(NUM_PINS), .SW(SENSE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hit_i(hit), .mode_o(mode), .pend_o(pend), .mask_o(mask),
    .prio_on_o(prio_on)
  );

  AST_ANY_FOLLOWS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o == '0) |-> !irq_any_o); // R11
endmodule

// File: tb/tb_irqpin_ctrl.sv
`timescale 1ns/100ps
module tb_irqpin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_i = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_o;
  logic        irq_any_o;

  int total = 0, bad = 0;
  logic done = 1'b0;
  logic [31:0] sense_sh = '0;

  always #2.5 clk = ~clk;

  irqpin_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .irq_any_o(irq_any_o)
  );

  function automatic logic [31:0] pbit(int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic set_mode(int n, logic [3:0] code);
    sense_sh[28-4*n +: 4] = code;
    wr(3'd0, sense_sh);
  endtask

  task automatic wait_cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    rd(3'd0, d); check("R1 sense", d, 32'h0);
    rd(3'd1, d); check("R1 prio", d, 32'h0);
    rd(3'd2, d); check("R1 pending", d, 32'h0);
    rd(3'd3, d); check("R1 mask", d, 32'hFF00_0000);
    check("R1 irq", {23'h0, irq_any_o, irq_o}, 32'h0);
  endtask

  task automatic t_bringup();
    logic [31:0] d;
    wr(3'd2, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFF00_0000);
    rd(3'd1, d); check("R10 prio readback", d, 32'hFFFF_FFFF);
    rd(3'd3, d); check("R9 all unmasked", d, 32'h0);
  endtask

  task automatic t_rising();
    logic [31:0] d;
    set_mode(0, 4'd1);
    rd(3'd0, d); check("R3 pin0 field in 31:28", d, 32'h1000_0000);
    pin_i[0] = 1'b1;
    wait_cyc(2);
    rd(3'd2, d); check("R12 not yet after two edges", d, 32'h0);
    wait_cyc(1);
    rd(3'd2, d); check("R12 R2 R4 pin0 pending at bit31", d, pbit(0));
    check("R11 irq pin0", {23'h0, irq_any_o, irq_o}, 32'h101);
    wr(3'd2, 32'h0);
    pin_i[0] = 1'b0;
    wait_cyc(4);
    rd(3'd2, d); check("R4 falling ignored in rising mode", d, 32'h0);
  endtask

  task automatic t_falling();
    logic [31:0] d;
    set_mode(7, 4'd0);
    rd(3'd0, d); check("R3 pin7 field in 3:0", d, 32'h1000_0000);
    pin_i[7] = 1'b1;
    wait_cyc(4);
    rd(3'd2, d); check("R5 rising ignored in falling mode", d, 32'h0);
    pin_i[7] = 1'b0;
    wait_cyc(4);
    rd(3'd2, d); check("R5 R2 pin7 pending at bit24", d, pbit(7));
    check("R11 irq pin7", {23'h0, irq_any_o, irq_o}, 32'h180);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_both();
    logic [31:0] d;
    set_mode(3, 4'd4);
    pin_i[3] = 1'b1;
    wait_cyc(4);
    rd(3'd2, d); check("R6 rise sets pin3", d, pbit(3));
    wr(3'd2, 32'h0);
    rd(3'd2, d); check("R8 cleared", d, 32'h0);
    pin_i[3] = 1'b0;
    wait_cyc(4);
    rd(3'd2, d); check("R6 fall sets pin3", d, pbit(3));
    wr(3'd2, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    set_mode(5, 4'd3);
    pin_i[5] = 1'b1;
    wait_cyc(4);
    wr(3'd2, 32'h0);
    rd(3'd2, d); check("R7 R8 high level survives clear", d, pbit(5));
    pin_i[5] = 1'b0;
    wait_cyc(4);
    rd(3'd2, d); check("R7 latched after level gone", d, pbit(5));
    wr(3'd2, 32'h0);
    rd(3'd2, d); check("R7 clear works once level gone", d, 32'h0);
    set_mode(2, 4'd2);
    wait_cyc(1);
    rd(3'd2, d); check("R7 low level on idle pin2", d, pbit(2));
    pin_i[2] = 1'b1;
    wait_cyc(4);
    wr(3'd2, 32'h0);
    rd(3'd2, d); check("R7 low level cleared after pin high", d, 32'h0);
  endtask

  task automatic t_keep_ones();
    logic [31:0] d;
    pin_i[0] = 1'b1; pin_i[3] = 1'b1;
    wait_cyc(4);
    rd(3'd2, d); check("R8 two pending", d, pbit(0) | pbit(3));
    wr(3'd2, ~pbit(3));
    rd(3'd2, d); check("R8 write one keeps pin0", d, pbit(0));
    pin_i[0] = 1'b0; pin_i[3] = 1'b0;
    wait_cyc(4);
    wr(3'd2, 32'h0);
    rd(3'd2, d); check("R8 all zeros clears all", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    pin_i[0] = 1'b1;
    wait_cyc(4);
    wr(3'd3, pbit(0));
    check("R9 masked pin0 quiet", {23'h0, irq_any_o, irq_o}, 32'h0);
    rd(3'd2, d); check("R9 mask keeps pending", d, pbit(0));
    wr(3'd4, 32'h00FF_FFFF);
    check("R9 zero bits of clear ignored", {23'h0, irq_any_o, irq_o}, 32'h0);
    wr(3'd3, ~pbit(0));
    wr(3'd4, pbit(0));
    rd(3'd3, d); check("R2 R9 only pin0 open", d, ~pbit(0) & 32'hFF00_0000);
    check("R9 unmasked pin0 fires", {23'h0, irq_any_o, irq_o}, 32'h101);
    wr(3'd4, 32'hFF00_0000);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(3'd1, 32'h0FFF_FFFF);
    check("R10 zero prio gates pin0", {23'h0, irq_any_o, irq_o}, 32'h0);
    pin_i[0] = 1'b0;
    wait_cyc(1);
    pin_i[1] = 1'b1; pin_i[1] = 1'b1;
    sense_sh[24 +: 4] = 4'd1;
    wr(3'd0, sense_sh);
    wait_cyc(4);
    check("R11 pin1 alone", {23'h0, irq_any_o, irq_o}, 32'h102);
    wr(3'd1, 32'h1000_0000);
    check("R10 pin0 prio 1 only", {23'h0, irq_any_o, irq_o}, 32'h101);
    wr(3'd1, 32'hFFFF_FFFF);
    check("R11 both pins", {23'h0, irq_any_o, irq_o}, 32'h103);
    pin_i[1] = 1'b0;
    wait_cyc(4);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_bad_code();
    logic [31:0] d;
    set_mode(6, 4'd7);
    pin_i[6] = 1'b1;
    wait_cyc(4);
    rd(3'd2, d); check("R13 code 7 rise", d, 32'h0);
    pin_i[6] = 1'b0;
    wait_cyc(4);
    set_mode(6, 4'hF);
    pin_i[6] = 1'b1;
    wait_cyc(4);
    rd(3'd2, d); check("R13 code 15 high", d, 32'h0);
    check("R13 no irq", {23'h0, irq_any_o, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bringup();
    t_rising();
    t_falling();
    t_both();
    t_level();
    t_keep_ones();
    t_mask();
    t_prio();
    t_bad_code();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule